// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction in decode with the destination registers of the two older instructions now in execute and memory. From that comparison it decides whether the pipeline front end must hold, whether a no-op goes into execute, and which value each ALU operand multiplexer in execute should take on the next cycle. The register file is assumed to write in the first half of a cycle and read in the second, so a producer that has reached writeback needs no help from this unit.

A two-bit run-time mode picks the policy. In forwarding mode, results are routed back from the memory or writeback stage, and only a load followed at once by a use of its result costs a cycle. In stall-only mode, nothing is forwarded, and a dependent instruction waits in decode until its producer has reached writeback. In the unprotected mode, the unit does nothing, and a dependent instruction reads whatever old value the register file still holds. A taken branch, resolved in execute, squashes the fetch and decode stages and overrides any stall request.

The operand selects are computed while the consumer is still in decode and are registered into execute. This keeps the comparators out of the execute-stage path.

Top module: `hz_unit`

## Requirements
- R1: In forwarding mode (mode 0), when a decode source that is in use matches the destination of a register-writing instruction in execute, that operand's select in the next cycle is 1 (memory-stage result). Select codes: 0 register file, 1 memory-stage result, 2 writeback-stage result.
- R2: In forwarding mode, when a used decode source matches only the destination of a register-writing instruction in memory, that operand's select in the next cycle is 2 (writeback-stage result).
- R3: When both the execute and memory producers match the same source, the younger execute producer wins, giving select 1.
- R4: Source register 0, or a source whose use flag is low, never causes a forward or a stall.
- R5: In forwarding mode, a used source that matches a load in execute raises a stall for exactly that cycle. Once the load has moved to memory there is no stall, and the operand takes select 2.
- R6: In stall-only mode (mode 1), a used source that matches a writing producer in execute or in memory raises a stall. This gives two stall cycles at distance one and one stall cycle at distance two. This mode never forwards (select stays 0).
- R7: A producer that has left the memory stage (distance three or more) causes neither a stall nor a forward.
- R8: A stall holds the program counter and the fetch/decode register and sends a bubble into execute. A cycle that sends a bubble leaves both selects at 0 in the next cycle.
- R9: In the unprotected mode (mode 2, and mode 3, which behaves the same), the unit never stalls and never forwards.
- R10: A taken branch flushes fetch/decode and sends a bubble into execute. It drops the program-counter and fetch/decode hold, even when a hazard is present.
- R11: While reset is held, both selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 forward, 1 stall-only, 2 or 3 unprotected |
| br_taken_i | input | 1 | Branch in execute resolved taken |
| id_rs1_i | input | 5 | Decode source register 1 |
| id_rs2_i | input | 5 | Decode source register 2 |
| id_use1_i | input | 1 | Decode instruction reads source 1 |
| id_use2_i | input | 1 | Decode instruction reads source 2 |
| ex_rd_i | input | 5 | Execute-stage destination register |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| ifid_flush_o | output | 1 | Squash the fetch/decode register |
| ex_bubble_o | output | 1 | Load a no-op into execute |
| fwd_a_o | output | 2 | Select for ALU operand A in execute |
| fwd_b_o | output | 2 | Select for ALU operand B in execute |

## Verification
The bench sweeps every combination of three register numbers (0, 1 and 2) over both sources and both producer destinations. It crosses this with every write, load, use-flag and branch setting under all four mode codes.

Using number 0 separates real matches from the register-zero exclusion. Using the same producer number in execute and memory exposes the priority between the two forward paths. Toggling the use flags shows that an unread source is ignored.

Short directed sequences then move a producer through the stages. They count the stall cycles it causes: two, then one in stall-only mode, one for a load in forwarding mode, and none in the unprotected mode.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    HM_FWD   = 2'd0,
    HM_STALL = 2'd1,
    HM_NONE  = 2'd2,
    HM_NONE2 = 2'd3
  } hz_mode_e;

  typedef enum logic [1:0] {
    FS_REG = 2'd0,
    FS_MEM = 2'd1,
    FS_WB  = 2'd2
  } fsel_e;

  typedef struct packed {
    logic hit_ex;
    logic hit_mem;
  } src_hit_t;

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
  import hz_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] rs_i,
  input  logic          use_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          ex_wr_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_wr_i,
  output src_hit_t      hit_o
);

  logic live;

  always_comb begin
    live          = use_i && (rs_i != '0);
    hit_o.hit_ex  = live && ex_wr_i  && (ex_rd_i  == rs_i);
    hit_o.hit_mem = live && mem_wr_i && (mem_rd_i == rs_i);
  end

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hz_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  hz_mode_e mode_i,
  input  src_hit_t hit_i [NSRC],
  input  logic     ex_load_i,
  input  logic     br_taken_i,
  output logic     pc_hold_o,
  output logic     ifid_hold_o,
  output logic     ifid_flush_o,
  output logic     ex_bubble_o
);

  logic any_ex;
  logic any_mem;
  logic need_stall;

  always_comb begin
    any_ex  = 1'b0;
    any_mem = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      any_ex  = any_ex  | hit_i[i].hit_ex;
      any_mem = any_mem | hit_i[i].hit_mem;
    end
  end

  always_comb begin
    unique case (mode_i)
      HM_FWD:   need_stall = any_ex && ex_load_i;
      HM_STALL: need_stall = any_ex || any_mem;
      default:  need_stall = 1'b0;
    endcase
  end

  always_comb begin
    pc_hold_o    = need_stall && !br_taken_i;
    ifid_hold_o  = need_stall && !br_taken_i;
    ifid_flush_o = br_taken_i;
    ex_bubble_o  = need_stall || br_taken_i;
  end

endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hz_mode_e mode_i,
  input  src_hit_t hit_i,
  input  logic     bubble_i,
  output fsel_e    sel_o
);

  fsel_e sel_d;
  fsel_e sel_q;
  logic  sel_en;

  assign sel_en = 1'b1;

  always_comb begin
    sel_d = FS_REG;
    if (!bubble_i && (mode_i == HM_FWD)) begin
      if (hit_i.hit_ex)       sel_d = FS_MEM;
      else if (hit_i.hit_mem) sel_d = FS_WB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= FS_REG;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_i |=> (sel_o == FS_REG)); // R8
  AST_STALLMODE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HM_STALL) |=> (sel_o == FS_REG)); // R6
  AST_NONEMODE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HM_NONE || mode_i == HM_NONE2) |=> (sel_o == FS_REG)); // R9
  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i.hit_ex && hit_i.hit_mem && !bubble_i && mode_i == HM_FWD) |=> (sel_o == FS_MEM)); // R3

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          br_taken_i,
  input  logic [RW-1:0] id_rs1_i,
  input  logic [RW-1:0] id_rs2_i,
  input  logic          id_use1_i,
  input  logic          id_use2_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          ex_wr_i,
  input  logic          ex_load_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_wr_i,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          ifid_flush_o,
  output logic          ex_bubble_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o
);

  localparam int SELW = 2;

  hz_mode_e       mode;
  logic [RW-1:0]  rs   [NSRC];
  logic           used [NSRC];
  src_hit_t       hit  [NSRC];
  fsel_e          sel  [NSRC];
  logic           bubble;

  assign mode    = hz_mode_e'(mode_i);
  assign rs[0]   = id_rs1_i;
  assign rs[1]   = id_rs2_i;
  assign used[0] = id_use1_i;
  assign used[1] = id_use2_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_cmp #(.RW(RW)) u_cmp (
      .rs_i     (rs[g]),
      .use_i    (used[g]),
      .ex_rd_i  (ex_rd_i),
      .ex_wr_i  (ex_wr_i),
      .mem_rd_i (mem_rd_i),
      .mem_wr_i (mem_wr_i),
      .hit_o    (hit[g])
    );

    hz_fwd_reg u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .hit_i    (hit[g]),
      .bubble_i (bubble),
      .sel_o    (sel[g])
    );
  end

  hz_stall_ctl #(.NSRC(NSRC)) u_ctl (
    .mode_i       (mode),
    .hit_i        (hit),
    .ex_load_i    (ex_load_i),
    .br_taken_i   (br_taken_i),
    .pc_hold_o    (pc_hold_o),
    .ifid_hold_o  (ifid_hold_o),
    .ifid_flush_o (ifid_flush_o),
    .ex_bubble_o  (bubble)
  );

  assign ex_bubble_o = bubble;
  assign fwd_a_o     = SELW'(sel[0]);
  assign fwd_b_o     = SELW'(sel[1]);

  AST_HOLD_GIVES_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold_o |-> (ex_bubble_o && ifid_hold_o)); // R8
  AST_BRANCH_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_i |-> (ifid_flush_o && ex_bubble_o && !pc_hold_o && !ifid_hold_o)); // R10
  AST_NONEMODE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1]) |-> !pc_hold_o); // R9
  AST_X0_NO_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_o != 2'd0) |-> ($past(id_rs1_i) != '0 && $past(id_use1_i))); // R4
  AST_X0_NO_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_o != 2'd0) |-> ($past(id_rs2_i) != '0 && $past(id_use2_i))); // R4
  AST_FWD_NO_STALL_NONLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && !ex_load_i) |-> !pc_hold_o); // R5

endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       br;
  logic [4:0] rs1, rs2, exrd, memrd;
  logic       use1, use2, exwr, exld, memwr;
  logic       pch, fdh, fdf, bub;
  logic [1:0] fa, fb;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hz_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .br_taken_i(br),
    .id_rs1_i(rs1), .id_rs2_i(rs2), .id_use1_i(use1), .id_use2_i(use2),
    .ex_rd_i(exrd), .ex_wr_i(exwr), .ex_load_i(exld),
    .mem_rd_i(memrd), .mem_wr_i(memwr),
    .pc_hold_o(pch), .ifid_hold_o(fdh), .ifid_flush_o(fdf), .ex_bubble_o(bub),
    .fwd_a_o(fa), .fwd_b_o(fb)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    br = 0; rs1 = 0; rs2 = 0; use1 = 0; use2 = 0;
    exrd = 0; exwr = 0; exld = 0; memrd = 0; memwr = 0;
  endtask

  function automatic int fsel(input int m, input bit bb, input bit hx, input bit hm);
    if (bb || m != 0) return 0;
    if (hx) return 1;
    if (hm) return 2;
    return 0;
  endfunction

  function automatic string ftag(input int m, input bit bb, input bit hx, input bit hm);
    if (bb) return "R8";
    if (m == 1) return "R6";
    if (m >= 2) return "R9";
    if (hx && hm) return "R3";
    if (hx) return "R1";
    if (hm) return "R2";
    return "R7";
  endfunction

  initial begin
    int stalls;
    rst_n = 0; mode = 0; idle();
    repeat (2) @(negedge clk);
    rs1 = 1; use1 = 1; exrd = 1; exwr = 1;
    @(negedge clk);
    chk("R11 fwd_a", fa, 0);
    chk("R11 fwd_b", fb, 0);
    idle();
    rst_n = 1;
    @(negedge clk);

    // Sweep
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int e = 0; e < 3; e++)
            for (int k = 0; k < 3; k++)
              for (int f = 0; f < 64; f++) begin
                bit hx1, hx2, hm1, hm2, st, bb;
                string stag;
                mode = m[1:0]; rs1 = a[4:0]; rs2 = b[4:0]; exrd = e[4:0]; memrd = k[4:0];
                use1 = f[0]; use2 = f[1]; exwr = f[2]; memwr = f[3]; exld = f[4]; br = f[5];
                hx1 = use1 && a != 0 && exwr && e == a;
                hx2 = use2 && b != 0 && exwr && e == b;
                hm1 = use1 && a != 0 && memwr && k == a;
                hm2 = use2 && b != 0 && memwr && k == b;
                if (m == 0) st = exld && (hx1 || hx2);
                else if (m == 1) st = hx1 || hx2 || hm1 || hm2;
                else st = 0;
                bb = st || br;
                if (br) stag = "R10";
                else if (m >= 2) stag = "R9";
                else if (m == 1) stag = "R6";
                else if ((a == 0 || b == 0) && (e == 0 || k == 0)) stag = "R4";
                else stag = "R5";
                #1;
                chk({stag, " pc_hold"}, pch, int'(st && !br));
                chk({stag, " ifid_hold R8"}, fdh, int'(st && !br));
                chk({stag, " ifid_flush"}, fdf, int'(br));
                chk({stag, " ex_bubble R8"}, bub, int'(bb));
                @(posedge clk); #1;
                chk({ftag(m, bb, hx1, hm1), " fwd_a"}, fa, fsel(m, bb, hx1, hm1));
                chk({ftag(m, bb, hx2, hm2), " fwd_b"}, fb, fsel(m, bb, hx2, hm2));
                @(negedge clk);
              end

    // Directed: stall-only, producer at distance one, then moving away (R6, R7)
    idle(); mode = 1; rs1 = 7; use1 = 1; exrd = 7; exwr = 1; stalls = 0;
    #1 stalls += pch;
    @(negedge clk); exwr = 0; memrd = 7; memwr = 1;
    #1 stalls += pch;
    @(negedge clk); memwr = 0;
    #1 stalls += pch;
    chk("R6 stall count distance one", stalls, 2);
    chk("R7 no stall after producer leaves memory", pch, 0);
    @(negedge clk);

    // Distance two in stall-only: one cycle (R6)
    idle(); mode = 1; rs2 = 9; use2 = 1; memrd = 9; memwr = 1; stalls = 0;
    #1 stalls += pch;
    @(negedge clk); memwr = 0;
    #1 stalls += pch;
    chk("R6 stall count distance two", stalls, 1);
    @(negedge clk);

    // Forwarding, load-use: one stall then writeback forward (R5)
    idle(); mode = 0; rs1 = 4; use1 = 1; exrd = 4; exwr = 1; exld = 1; stalls = 0;
    #1 stalls += pch;
    @(negedge clk); exwr = 0; exld = 0; memrd = 4; memwr = 1;
    #1 stalls += pch;
    chk("R5 load-use stall count", stalls, 1);
    @(posedge clk); #1;
    chk("R5 load result from writeback", fa, 2);
    @(negedge clk);

    // Unprotected mode: dependent pair gives no stall and no forward (R9)
    idle(); mode = 2; rs1 = 3; use1 = 1; exrd = 3; exwr = 1; stalls = 0;
    #1 stalls += pch;
    @(negedge clk); exwr = 0; memrd = 3; memwr = 1;
    #1 stalls += pch;
    @(posedge clk); #1;
    chk("R9 stall count unprotected", stalls, 0);
    chk("R9 stale operand select", fa, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=below limit", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule